// File: doc/BRIEF.md
# Wide Modular Add/Subtract Unit

This block adds or subtracts two wide unsigned operands and folds the result back toward a modulus with a single conditional correction step. The modulus is not an operand: it sits in a dedicated register that has its own simple write port. Software loads that register once and then issues any number of operations against it.

An operation starts when the valid strobe is high at a clock edge. The strobe carries operand A, operand B and an add/subtract select. The registered result and a one-cycle result-valid flag appear on the next cycle. Only one correction is applied. If an operand is already at or above the modulus, the result may still be at or above it. The unit drives no condition flags of any kind.

Addition forms the full sum, one bit wider than the operands. It takes the modulus away once if that sum is at or above the modulus. Subtraction forms the plain difference in operand width. It adds the modulus back when the most significant bit of that difference is set.

Top module: `modsum_unit`

## Requirements
- R1: While reset is active and after its release, with no operation issued, the result-valid output is 0 and the result output is all zeros.
- R2: For an addition (`op_sub` = 0) whose full-width sum A+B is below the modulus, the result equals A+B.
- R3: For an addition whose full sum is greater than or equal to the modulus, the result equals that sum minus the modulus. An exact match therefore gives zero.
- R4: The comparison against the modulus uses the sum including its carry-out bit. A sum that overflows the operand width is corrected even when its truncated low part is below the modulus, and the corrected value is truncated to operand width.
- R5: Only one correction is made. For operands above the modulus, the addition result is the sum minus one modulus, even if that value is still at or above the modulus.
- R6: For a subtraction (`op_sub` = 1) whose operand-width difference A−B (borrow-in zero) has its most significant bit clear, the result is that difference unchanged.
- R7: For a subtraction whose difference has its most significant bit set, the result is the difference plus the modulus, truncated to operand width.
- R8: The subtraction decision follows only the most significant bit of the difference and not the borrow. A difference with the top bit set is corrected even without a borrow. A wrapped difference with the top bit clear is returned unchanged.
- R9: The result and its valid flag register one cycle after the valid strobe. Result-valid is high for exactly one cycle per strobed cycle, so back-to-back strobes give back-to-back results.
- R10: A modulus write applies to operations that start on the following cycle or later. An operation strobed in the same cycle as the write uses the previous modulus.
- R11: In cycles without a strobe, the result output holds its last value, regardless of operand, select or modulus-write activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mod_we | input | 1 | Modulus register write enable |
| mod_wdata | input | WIDTH | Value loaded into the modulus register |
| op_valid | input | 1 | Starts an operation in this cycle |
| op_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B (subtrahend for subtraction) |
| res_valid | output | 1 | High for one cycle when a new result is presented |
| res_data | output | WIDTH | Registered corrected result |

## Verification
The bench builds the unit with WIDTH set to 16 instead of the default 256. At that width, carry-out of the sum, an exact match with the modulus, and differences whose top bit is set without a borrow can all be reached with short, readable hex constants. The structure is identical at every width, because every path is sized from the same parameter. Those carry and sign boundaries are the cases that separate a full-width comparison from a truncated one, and a sign-bit test from a borrow test.

// File: rtl/modsum_pkg.sv
package modsum_pkg;

  typedef enum logic {
    MS_OP_ADD = 1'b0,
    MS_OP_SUB = 1'b1
  } ms_op_e;

endpackage

// File: rtl/modsum_rst_sync.sv
module modsum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/modsum_modreg.sv
module modsum_modreg #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mod_q
);

  logic [WIDTH-1:0] mod_d;

  always_comb begin
    mod_d = mod_q;
    if (wr_en) begin
      mod_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
    end else if (wr_en) begin
      mod_q <= mod_d;
    end
  end

endmodule

// File: rtl/modsum_addpath.sv
module modsum_addpath #(
  parameter int WIDTH = 256
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] modv,
  output logic [WIDTH-1:0] result
);

  localparam int SUMW = WIDTH + 1;

  logic [SUMW-1:0] full_sum;
  logic [SUMW-1:0] mod_ext;
  logic [SUMW-1:0] reduced;
  logic            at_or_above;

  always_comb begin
    mod_ext     = {1'b0, modv};
    full_sum    = {1'b0, opa} + {1'b0, opb};
    reduced     = full_sum - mod_ext;
    at_or_above = (full_sum >= mod_ext);
    result      = at_or_above ? reduced[WIDTH-1:0] : full_sum[WIDTH-1:0];
  end

endmodule

// File: rtl/modsum_subpath.sv
module modsum_subpath #(
  parameter int WIDTH = 256
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] modv,
  output logic [WIDTH-1:0] result
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] restored;
  logic             sign_set;

  always_comb begin
    diff     = opa - opb;
    sign_set = diff[MSB];
    restored = diff + modv;
    result   = sign_set ? restored : diff;
  end

endmodule

// File: rtl/modsum_unit.sv
module modsum_unit
  import modsum_pkg::*;
#(
  parameter int WIDTH      = 256,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_we,
  input  logic [WIDTH-1:0] mod_wdata,
  input  logic             op_valid,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data
);

  logic             core_rst_n;
  logic [WIDTH-1:0] mod_q;
  logic [WIDTH-1:0] add_res;
  logic [WIDTH-1:0] sub_res;
  logic [WIDTH-1:0] sel_res;
  logic [WIDTH-1:0] res_d;
  logic             vld_d;
  logic [WIDTH-1:0] res_q;
  logic             vld_q;
  ms_op_e           op_kind;

  modsum_rst_sync #(
    .STAGES(SYNC_DEPTH)
  ) u_rst_sync (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (core_rst_n)
  );

  modsum_modreg #(
    .WIDTH(WIDTH)
  ) u_modreg (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .wr_en  (mod_we),
    .wr_data(mod_wdata),
    .mod_q  (mod_q)
  );

  modsum_addpath #(
    .WIDTH(WIDTH)
  ) u_addpath (
    .opa   (op_a),
    .opb   (op_b),
    .modv  (mod_q),
    .result(add_res)
  );

  modsum_subpath #(
    .WIDTH(WIDTH)
  ) u_subpath (
    .opa   (op_a),
    .opb   (op_b),
    .modv  (mod_q),
    .result(sub_res)
  );

  always_comb begin
    op_kind = ms_op_e'(op_sub);
    unique case (op_kind)
      MS_OP_SUB: sel_res = sub_res;
      default:   sel_res = add_res;
    endcase
  end

  always_comb begin
    vld_d = op_valid;
    res_d = res_q;
    if (op_valid) begin
      res_d = sel_res;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      res_q <= '0;
    end else if (op_valid) begin
      res_q <= res_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = res_q;

endmodule

// File: rtl/modsum_unit_chk.sv
module modsum_unit_chk #(
  parameter int WIDTH = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_we,
  input logic [WIDTH-1:0] mod_wdata,
  input logic [WIDTH-1:0] mod_q,
  input logic             op_valid,
  input logic             op_sub,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             res_valid,
  input logic [WIDTH-1:0] res_data
);

  logic [WIDTH:0]   chk_sum;
  logic [WIDTH-1:0] chk_diff;

  always_comb begin
    chk_sum  = {1'b0, op_a} + {1'b0, op_b};
    chk_diff = op_a - op_b;
  end

  // R9: a strobe is followed by a result-valid pulse
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R9: no strobe, no result-valid in the next cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  // R11: result holds across idle cycles
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data));

  // R2: addition below the modulus passes the sum through
  a_r2_add_below: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sub && (chk_sum < {1'b0, mod_q}))
      |=> (res_data == $past(chk_sum[WIDTH-1:0])));

  // R6: subtraction with clear sign bit passes the difference through
  a_r6_sub_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sub && !chk_diff[WIDTH-1])
      |=> (res_data == $past(chk_diff)));

  // R10: a modulus write is visible from the next cycle
  a_r10_mod_load: assert property (@(posedge clk) disable iff (!rst_n)
    mod_we |=> (mod_q == $past(mod_wdata)));

endmodule

bind modsum_unit modsum_unit_chk #(
  .WIDTH(WIDTH)
) u_modsum_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .mod_we   (mod_we),
  .mod_wdata(mod_wdata),
  .mod_q    (mod_q),
  .op_valid (op_valid),
  .op_sub   (op_sub),
  .op_a     (op_a),
  .op_b     (op_b),
  .res_valid(res_valid),
  .res_data (res_data)
);

// File: tb/modsum_unit_tb_top.sv
module modsum_unit_tb_top;

  localparam int W        = 16;
  localparam int NVEC     = 11;
  localparam int VECW     = 1 + 3 * W;
  localparam int WDOG_MAX = 20000;

  logic         clk;
  logic         rst_n;
  logic         mod_we;
  logic [W-1:0] mod_wdata;
  logic         op_valid;
  logic         op_sub;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         res_valid;
  logic [W-1:0] res_data;

  int n_checks;
  int n_fails;
  int cyc;

  // {sub, a, b, modulus}
  localparam logic [VECW-1:0] VEC [NVEC] = '{
    {1'b0, 16'h0010, 16'h0020, 16'h0100},  // 0 R2 below modulus
    {1'b0, 16'h0080, 16'h0080, 16'h0100},  // 1 R3 exact match gives zero
    {1'b0, 16'h00F0, 16'h0020, 16'h0100},  // 2 R3 above modulus
    {1'b0, 16'hFFFF, 16'hFFFF, 16'hFFF1},  // 3 R4 carry-out, truncation
    {1'b0, 16'h8000, 16'h8000, 16'hFFFF},  // 4 R4 low part below modulus
    {1'b0, 16'h0500, 16'h0100, 16'h0100},  // 5 R5 one correction only
    {1'b1, 16'h0300, 16'h0100, 16'h1000},  // 6 R6 positive difference
    {1'b1, 16'h0100, 16'h0300, 16'h1000},  // 7 R7 negative, modulus added
    {1'b1, 16'h9000, 16'h0001, 16'h1000},  // 8 R8 sign set without borrow
    {1'b1, 16'h0001, 16'h8002, 16'h1000},  // 9 R8 borrow, sign clear
    {1'b1, 16'h1234, 16'h1234, 16'h1000}   // 10 R6 equal operands
  };

  modsum_unit #(
    .WIDTH(W)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_we   (mod_we),
    .mod_wdata(mod_wdata),
    .op_valid (op_valid),
    .op_sub   (op_sub),
    .op_a     (op_a),
    .op_b     (op_b),
    .res_valid(res_valid),
    .res_data (res_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] model(input logic sub, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic [W-1:0] m);
    logic [W:0]   s;
    logic [W-1:0] d;
    if (!sub) begin
      s = {1'b0, a} + {1'b0, b};
      if (s >= {1'b0, m}) s = s - {1'b0, m};
      return s[W-1:0];
    end
    d = a - b;
    if (d[W-1]) d = d + m;
    return d;
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0:       return "R2";
      1, 2:    return "R3";
      3, 4:    return "R4";
      5:       return "R5";
      6, 10:   return "R6";
      7:       return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_mod(input logic [W-1:0] m);
    mod_we    = 1'b1;
    mod_wdata = m;
    tick();
    mod_we    = 1'b0;
  endtask

  task automatic issue(input logic sub, input logic [W-1:0] a, input logic [W-1:0] b);
    op_valid = 1'b1;
    op_sub   = sub;
    op_a     = a;
    op_b     = b;
    tick();
    op_valid = 1'b0;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_MAX) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_MAX);
        finish_run();
      end
    end
  end

  initial begin
    logic [W-1:0] held;
    n_checks  = 0;
    n_fails   = 0;
    rst_n     = 1'b0;
    mod_we    = 1'b0;
    mod_wdata = '0;
    op_valid  = 1'b0;
    op_sub    = 1'b0;
    op_a      = '0;
    op_b      = '0;

    // R1: state during reset
    tick();
    tick();
    check("R1", {15'd0, res_valid}, 16'd0);
    check("R1", res_data, 16'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1", {15'd0, res_valid}, 16'd0);
    check("R1", res_data, 16'd0);

    // Table walk: load modulus, strobe, then sample the registered result
    for (int i = 0; i < NVEC; i++) begin
      logic         vs;
      logic [W-1:0] va, vb, vm;
      {vs, va, vb, vm} = VEC[i];
      load_mod(vm);
      issue(vs, va, vb);
      check(tag_of(i), res_data, model(vs, va, vb, vm));
      check("R9", {15'd0, res_valid}, 16'd1);
      tick();
      check("R9", {15'd0, res_valid}, 16'd0);
    end

    // R11: idle cycles with moving inputs and a modulus write
    held   = res_data;
    op_a   = 16'hAAAA;
    op_b   = 16'h5555;
    op_sub = 1'b0;
    load_mod(16'h0003);
    tick();
    check("R11", res_data, held);
    check("R11", {15'd0, res_valid}, 16'd0);

    // R10: write and strobe in the same cycle use the old modulus
    load_mod(16'h0100);
    mod_we    = 1'b1;
    mod_wdata = 16'h0040;
    issue(1'b0, 16'h0030, 16'h0020);
    mod_we    = 1'b0;
    check("R10", res_data, 16'h0050);
    issue(1'b0, 16'h0030, 16'h0020);
    check("R10", res_data, 16'h0010);

    // R9: back-to-back strobes give back-to-back results
    op_valid = 1'b1;
    op_sub   = 1'b1;
    op_a     = 16'h0005;
    op_b     = 16'h0007;
    tick();
    check("R7", res_data, 16'h003E);
    check("R9", {15'd0, res_valid}, 16'd1);
    op_sub = 1'b0;
    op_a   = 16'h0030;
    op_b   = 16'h0010;
    tick();
    op_valid = 1'b0;
    check("R3", res_data, 16'h0000);
    check("R9", {15'd0, res_valid}, 16'd1);
    tick();
    check("R9", {15'd0, res_valid}, 16'd0);
    check("R11", res_data, 16'h0000);

    // R1: reset mid-run clears the outputs
    issue(1'b0, 16'h0001, 16'h0002);
    rst_n = 1'b0;
    tick();
    check("R1", res_data, 16'd0);
    check("R1", {15'd0, res_valid}, 16'd0);
    rst_n = 1'b1;
    repeat (3) tick();

    finish_run();
  end

endmodule